// File: doc/BRIEF.md
# Dual-Processor Mailbox Interrupt Registers

This block is a small register file shared by two processors. A host processor reaches it through an APB-style bus with zero wait states. A peer DSP reaches it through a simple parallel register port made of a chip select, a write strobe, an address and data. The block holds three 16-bit registers: a mailbox for host-to-DSP interrupts, a mailbox for DSP-to-host interrupts, and a shared token register. Either processor can read all three registers, but each processor may change only the fields it owns.

Both mailboxes use the same layout:

- bit 15 is the interrupt bit;
- bit 14 is the clear flag;
- bit 13 is the done flag;
- bits 12:0 hold a message.

The sending processor writes the message and raises the interrupt. Raising the interrupt also raises the clear and done flags. The receiving processor can only lower those two flags. Lowering the clear flag also drops the interrupt. Lowering the done flag tells the sender that the receiver has finished with the buffer the message pointed to.

The host-to-DSP interrupt leaves the block on an active-low pin. The DSP-to-host interrupt leaves the block as an active-high level. In the token register, the host owns the low byte and the DSP owns the high byte, so software can mark buffer areas as full or empty.

Top module: `xproc_mailbox`

## Requirements
- R1: After reset, all three registers read as zero, `dsp_irq_n` is 1 and `host_irq` is 0.
- R2: A sender write with bit 15 set makes bits 15, 14 and 13 of that mailbox read 1 after the write edge. The host is the sender for the host-to-DSP mailbox and the DSP is the sender for the DSP-to-host mailbox.
- R3: Every sender write loads bits 12:0 with write-data bits 12:0. A sender write with bit 15 at 0 leaves bits 15:13 unchanged.
- R4: A receiver write with bit 14 at 0 lowers bits 14 and 15 of that mailbox. A receiver write with bit 14 at 1 leaves them unchanged.
- R5: A receiver write with bit 13 at 0 lowers only bit 13. Bit 15 keeps its value when bit 14 of the same write is 1.
- R6: A receiver write cannot change bit 15 or bits 12:0. A sender write of 0 to bit 14 or bit 13 changes neither of them.
- R7: If a sender write with bit 15 set and a receiver write that lowers bits 14 and 13 fall on the same clock edge, the mailbox ends with bits 15:13 all at 1.
- R8: `dsp_irq_n` is the inverse of host-to-DSP bit 15, and `host_irq` equals DSP-to-host bit 15. Both change on the same edge as that bit.
- R9: Token bits 7:0 change only on host writes, and token bits 15:8 change only on DSP writes. Host reads return the token zero-extended, so bits 31:16 read as 0.
- R10: Register index 0 selects the token, 1 the host-to-DSP mailbox, 2 the DSP-to-host mailbox, and 3 reads as zero. The host index is `paddr[3:2]` and the DSP index is `dsp_addr`. A host write takes effect only in the access phase (`psel`, `penable` and `pwrite` all high). Read data is zero unless the port is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Host bus select |
| penable | input | 1 | Host bus access phase |
| pwrite | input | 1 | Host bus write (1) or read (0) |
| paddr | input | HOST_AW | Host byte address; bits 3:2 pick the register |
| pwdata | input | HOST_DW | Host write data |
| prdata | output | HOST_DW | Host read data, zero-extended |
| dsp_cs | input | 1 | DSP port select |
| dsp_we | input | 1 | DSP write strobe |
| dsp_addr | input | 2 | DSP register index |
| dsp_wdata | input | MSG_W+3 | DSP write data |
| dsp_rdata | output | MSG_W+3 | DSP read data |
| dsp_irq_n | output | 1 | Active-low interrupt toward the DSP |
| host_irq | output | 1 | Active-high interrupt toward the host |

## Verification
The interesting collision is a sender raising the interrupt on the same edge that the receiver writes zeros to the clear and done flags. The bench provokes it by placing the host bus access phase on the same clock as a DSP write strobe to the host-to-DSP mailbox. It then judges the result by reading back all three control bits at 1 and checking that the DSP interrupt pin is still asserted. A second case, where the two ports write their own token bytes on the same cycle, confirms that the byte lanes stay independent.

// File: rtl/xmb_pkg.sv
package xmb_pkg;

   // Register selector shared by both ports
   typedef enum logic [1:0] {
      IDX_TOKEN = 2'd0,
      IDX_H2D   = 2'd1,
      IDX_D2H   = 2'd2,
      IDX_NONE  = 2'd3
   } reg_idx_e;

   // Offsets of the control bits above the message field
   localparam int CTL_DONE_OFS = 0;
   localparam int CTL_CLR_OFS  = 1;
   localparam int CTL_INT_OFS  = 2;

endpackage

// File: rtl/mbox_irq_reg.sv
module mbox_irq_reg #(
   parameter int MSG_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snd_we,
   input  logic [MSG_W+2:0] snd_wdata,
   input  logic             rcv_we,
   input  logic [MSG_W+2:0] rcv_wdata,
   output logic [MSG_W+2:0] q
);
   import xmb_pkg::*;

   localparam int INT_B  = MSG_W + CTL_INT_OFS;
   localparam int CLR_B  = MSG_W + CTL_CLR_OFS;
   localparam int DONE_B = MSG_W + CTL_DONE_OFS;

   if (MSG_W < 1) begin : g_bad_msg
      $error("mbox_irq_reg: MSG_W must be positive");
   end

   logic             irq_q, clr_q, done_q;
   logic [MSG_W-1:0] msg_q;
   logic             snd_set, rcv_clr, rcv_done;
   logic             unused_rcv;

   assign snd_set  = snd_we & snd_wdata[INT_B];
   assign rcv_clr  = rcv_we & ~rcv_wdata[CLR_B];
   assign rcv_done = rcv_we & ~rcv_wdata[DONE_B];
   assign unused_rcv = ^{rcv_wdata[INT_B], rcv_wdata[MSG_W-1:0],
                         snd_wdata[CLR_B], snd_wdata[DONE_B]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         clr_q  <= 1'b0;
         done_q <= 1'b0;
         msg_q  <= '0;
      end else begin
         if (snd_we) msg_q <= snd_wdata[MSG_W-1:0];
         if (snd_set) begin
            // a raise beats any same-edge lowering
            irq_q  <= 1'b1;
            clr_q  <= 1'b1;
            done_q <= 1'b1;
         end else begin
            if (rcv_clr) begin
               irq_q <= 1'b0;
               clr_q <= 1'b0;
            end
            if (rcv_done) done_q <= 1'b0;
         end
      end
   end

   assign q = {irq_q, clr_q, done_q, msg_q};

endmodule

// File: rtl/token_reg.sv
module token_reg #(
   parameter int                 BYTES  = 2,
   parameter logic [BYTES-1:0]   A_MASK = 2'b01
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               a_we,
   input  logic [8*BYTES-1:0] a_wdata,
   input  logic               b_we,
   input  logic [8*BYTES-1:0] b_wdata,
   output logic [8*BYTES-1:0] q
);
   if (BYTES < 1) begin : g_bad_bytes
      $error("token_reg: BYTES must be positive");
   end

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      logic       we;
      logic [7:0] wd;
      logic [7:0] lane_q;
      if (A_MASK[g]) begin : g_a
         assign we = a_we;
         assign wd = a_wdata[8*g +: 8];
      end else begin : g_b
         assign we = b_we;
         assign wd = b_wdata[8*g +: 8];
      end
      always_ff @(posedge clk) begin
         if (!rst_n)  lane_q <= 8'h00;
         else if (we) lane_q <= wd;
      end
      assign q[8*g +: 8] = lane_q;
   end

   logic unused_lanes;
   assign unused_lanes = ^{a_wdata, b_wdata};

endmodule

// File: rtl/xproc_mailbox.sv
module xproc_mailbox
   import xmb_pkg::*;
#(
   parameter int HOST_DW = 32,
   parameter int HOST_AW = 4,
   parameter int MSG_W   = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               psel,
   input  logic               penable,
   input  logic               pwrite,
   input  logic [HOST_AW-1:0] paddr,
   input  logic [HOST_DW-1:0] pwdata,
   output logic [HOST_DW-1:0] prdata,
   input  logic               dsp_cs,
   input  logic               dsp_we,
   input  logic [1:0]         dsp_addr,
   input  logic [MSG_W+2:0]   dsp_wdata,
   output logic [MSG_W+2:0]   dsp_rdata,
   output logic               dsp_irq_n,
   output logic               host_irq
);
   localparam int MB_W      = MSG_W + 3;
   localparam int TOK_BYTES = MB_W / 8;
   localparam int IDX_LSB   = $clog2(HOST_DW / 8);
   localparam logic [TOK_BYTES-1:0] HOST_LANES = TOK_BYTES'((1 << (TOK_BYTES / 2)) - 1);

   if (MB_W % 8 != 0 || TOK_BYTES < 2) begin : g_bad_width
      $error("xproc_mailbox: MSG_W+3 must be a multiple of 8, at least 16");
   end
   if (HOST_DW < MB_W) begin : g_bad_hdw
      $error("xproc_mailbox: host data narrower than a register");
   end
   if (HOST_AW < IDX_LSB + 2) begin : g_bad_haw
      $error("xproc_mailbox: host address too narrow for the index");
   end

   reg_idx_e h_idx, d_idx;
   logic     h_wr, d_wr;
   logic [MB_W-1:0] h2d_q, d2h_q, tok_q;
   logic     unused_host;

   assign h_idx = reg_idx_e'(paddr[IDX_LSB+1:IDX_LSB]);
   assign d_idx = reg_idx_e'(dsp_addr);
   assign h_wr  = psel & penable & pwrite;
   assign d_wr  = dsp_cs & dsp_we;
   assign unused_host = ^{paddr, pwdata};

   // host is sender here, DSP the receiver
   mbox_irq_reg #(.MSG_W(MSG_W)) u_h2d (
      .clk       (clk),
      .rst_n     (rst_n),
      .snd_we    (h_wr && h_idx == IDX_H2D),
      .snd_wdata (pwdata[MB_W-1:0]),
      .rcv_we    (d_wr && d_idx == IDX_H2D),
      .rcv_wdata (dsp_wdata),
      .q         (h2d_q)
   );

   // DSP is sender here, host the receiver
   mbox_irq_reg #(.MSG_W(MSG_W)) u_d2h (
      .clk       (clk),
      .rst_n     (rst_n),
      .snd_we    (d_wr && d_idx == IDX_D2H),
      .snd_wdata (dsp_wdata),
      .rcv_we    (h_wr && h_idx == IDX_D2H),
      .rcv_wdata (pwdata[MB_W-1:0]),
      .q         (d2h_q)
   );

   token_reg #(.BYTES(TOK_BYTES), .A_MASK(HOST_LANES)) u_tok (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_we    (h_wr && h_idx == IDX_TOKEN),
      .a_wdata (pwdata[MB_W-1:0]),
      .b_we    (d_wr && d_idx == IDX_TOKEN),
      .b_wdata (dsp_wdata),
      .q       (tok_q)
   );

   function automatic logic [MB_W-1:0] rd_sel(reg_idx_e idx);
      case (idx)
         IDX_TOKEN: rd_sel = tok_q;
         IDX_H2D:   rd_sel = h2d_q;
         IDX_D2H:   rd_sel = d2h_q;
         default:   rd_sel = '0;
      endcase
   endfunction

   assign prdata    = psel   ? HOST_DW'(rd_sel(h_idx)) : '0;
   assign dsp_rdata = dsp_cs ? rd_sel(d_idx) : '0;

   assign dsp_irq_n = ~h2d_q[MB_W-1];
   assign host_irq  = d2h_q[MB_W-1];

endmodule

// File: rtl/xproc_mailbox_chk.sv
module xproc_mailbox_chk #(
   parameter int HOST_DW = 32,
   parameter int HOST_AW = 4,
   parameter int MSG_W   = 13
) (
   input logic               clk,
   input logic               rst_n,
   input logic               psel,
   input logic               penable,
   input logic               pwrite,
   input logic [HOST_AW-1:0] paddr,
   input logic [HOST_DW-1:0] pwdata,
   input logic               dsp_cs,
   input logic               dsp_we,
   input logic [1:0]         dsp_addr,
   input logic [MSG_W+2:0]   dsp_wdata,
   input logic [MSG_W+2:0]   h2d_q,
   input logic [MSG_W+2:0]   tok_q,
   input logic               host_irq
);
   localparam int MB_W = MSG_W + 3;
   localparam int IL   = $clog2(HOST_DW / 8);
   localparam int IB   = MB_W - 1;
   localparam int CB   = MB_W - 2;
   localparam int DB   = MB_W - 3;

   logic hw_h2d, dw_h2d, dw_d2h, dw_tok, h_set;
   logic unused_chk;

   assign hw_h2d = psel & penable & pwrite & (paddr[IL+1:IL] == 2'd1);
   assign dw_h2d = dsp_cs & dsp_we & (dsp_addr == 2'd1);
   assign dw_d2h = dsp_cs & dsp_we & (dsp_addr == 2'd2);
   assign dw_tok = dsp_cs & dsp_we & (dsp_addr == 2'd0);
   assign h_set  = hw_h2d & pwdata[IB];
   assign unused_chk = ^{paddr, pwdata};

   // R2
   h2d_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      h_set |=> (h2d_q[IB] && h2d_q[CB] && h2d_q[DB]));

   // R3
   msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_h2d |=> h2d_q[MSG_W-1:0] == $past(h2d_q[MSG_W-1:0]));

   // R4
   rcv_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dw_h2d && !dsp_wdata[CB] && !h_set) |=> (!h2d_q[IB] && !h2d_q[CB]));

   // R5
   done_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dw_h2d && dsp_wdata[CB] && !dsp_wdata[DB] && !h_set)
      |=> (!h2d_q[DB] && h2d_q[IB] == $past(h2d_q[IB])));

   // R6
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(h2d_q[IB]) |-> $past(h_set));

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_set && dw_h2d) |=> (h2d_q[CB] && h2d_q[DB]));

   // R8
   host_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_irq) |-> $past(dw_d2h && dsp_wdata[IB]));

   // R9
   tok_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dw_tok |=> tok_q[MB_W-1:8] == $past(tok_q[MB_W-1:8]));

endmodule

bind xproc_mailbox xproc_mailbox_chk #(
   .HOST_DW(HOST_DW), .HOST_AW(HOST_AW), .MSG_W(MSG_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .psel      (psel),
   .penable   (penable),
   .pwrite    (pwrite),
   .paddr     (paddr),
   .pwdata    (pwdata),
   .dsp_cs    (dsp_cs),
   .dsp_we    (dsp_we),
   .dsp_addr  (dsp_addr),
   .dsp_wdata (dsp_wdata),
   .h2d_q     (h2d_q),
   .tok_q     (tok_q),
   .host_irq  (host_irq)
);

// File: tb/xproc_mailbox_test.sv
module xproc_mailbox_test;
   localparam int CLK_PERIOD = 10;
   localparam int K_HOST = 0;
   localparam int K_DSP  = 1;
   localparam int K_PINS = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [3:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        dsp_cs = 1'b0, dsp_we = 1'b0;
   logic [1:0]  dsp_addr = '0;
   logic [15:0] dsp_wdata = '0;
   logic [15:0] dsp_rdata;
   logic        dsp_irq_n, host_irq;

   typedef struct {
      int          kind;
      int          idx;
      logic [31:0] exp;
      string       tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   int n_push = 0, n_done = 0;
   int total = 0, bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xproc_mailbox uut (
      .clk(clk), .rst_n(rst_n),
      .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .dsp_cs(dsp_cs), .dsp_we(dsp_we), .dsp_addr(dsp_addr),
      .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata),
      .dsp_irq_n(dsp_irq_n), .host_irq(host_irq)
   );

   // monitor: pops expectations and compares against the ports
   initial begin
      sb_item_t it;
      logic [31:0] act;
      forever begin
         wait (sb_q.size() != 0);
         it = sb_q.pop_front();
         @(negedge clk);
         act = '0;
         if (it.kind == K_HOST) begin
            psel = 1'b1; pwrite = 1'b0; penable = 1'b0;
            paddr = 4'(it.idx << 2);
            #1 act = prdata;
            psel = 1'b0;
         end else if (it.kind == K_DSP) begin
            dsp_cs = 1'b1; dsp_we = 1'b0; dsp_addr = 2'(it.idx);
            #1 act = {16'h0, dsp_rdata};
            dsp_cs = 1'b0;
         end else begin
            #1 act = {30'h0, dsp_irq_n, host_irq};
         end
         total++;
         if (act !== it.exp) begin
            bad++;
            $display("FAIL %s kind=%0d idx=%0d act=%h exp=%h",
                     it.tag, it.kind, it.idx, act, it.exp);
         end
         n_done++;
      end
   end

   task automatic expect_val(int kind, int idx, logic [31:0] exp, string tag);
      sb_item_t it;
      it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      n_push++;
      wait (n_done == n_push);
   endtask

   task automatic expect_both(int idx, logic [15:0] exp, string tag);
      expect_val(K_HOST, idx, {16'h0, exp}, tag);
      expect_val(K_DSP,  idx, {16'h0, exp}, tag);
   endtask

   task automatic host_wr(int idx, logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0;
      paddr = 4'(idx << 2); pwdata = d;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic host_setup_only(int idx, logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0;
      paddr = 4'(idx << 2); pwdata = d;
      @(negedge clk);
      psel = 1'b0; pwrite = 1'b0;
   endtask

   task automatic dsp_wr(int idx, logic [15:0] d);
      @(negedge clk);
      dsp_cs = 1'b1; dsp_we = 1'b1; dsp_addr = 2'(idx); dsp_wdata = d;
      @(negedge clk);
      dsp_cs = 1'b0; dsp_we = 1'b0;
   endtask

   // host access phase and DSP strobe on the same edge
   task automatic both_wr(int h_idx, logic [31:0] hd, int d_idx, logic [15:0] dd);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0;
      paddr = 4'(h_idx << 2); pwdata = hd;
      @(negedge clk);
      penable = 1'b1;
      dsp_cs = 1'b1; dsp_we = 1'b1; dsp_addr = 2'(d_idx); dsp_wdata = dd;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      dsp_cs = 1'b0; dsp_we = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      expect_both(0, 16'h0000, "R1 token");
      expect_both(1, 16'h0000, "R1 h2d");
      expect_both(2, 16'h0000, "R1 d2h");
      expect_val(K_PINS, 0, 32'h2, "R1 pins");

      // R2 host raises host-to-DSP interrupt with message
      host_wr(1, 32'h0000_8123);
      expect_both(1, 16'hE123, "R2 h2d set");
      // R8 active-low pin asserted
      expect_val(K_PINS, 0, 32'h0, "R8 dsp_irq_n low");

      // R3 message update without raise keeps control bits
      host_wr(1, 32'h0000_6ABC);
      expect_both(1, 16'hEABC, "R3 msg only");

      // R6 receiver writing ones everywhere changes nothing
      dsp_wr(1, 16'hFFFF);
      expect_val(K_DSP, 1, 32'h0000_EABC, "R6 rcv ignored");

      // R5 done flag lowered alone
      dsp_wr(1, 16'h4000);
      expect_val(K_HOST, 1, 32'h0000_CABC, "R5 done only");
      expect_val(K_PINS, 0, 32'h0, "R5 irq kept");

      // R4 clear flag lowered drops the interrupt
      dsp_wr(1, 16'h2000);
      expect_both(1, 16'h0ABC, "R4 clear");
      expect_val(K_PINS, 0, 32'h2, "R8 dsp_irq_n high");

      // R6 sender cannot lower clear or done
      host_wr(1, 32'h0000_8001);
      host_wr(1, 32'h0000_0001);
      expect_val(K_DSP, 1, 32'h0000_E001, "R6 sender zeros");
      dsp_wr(1, 16'h0000);
      expect_val(K_DSP, 1, 32'h0000_0001, "R4 full clear");

      // R2 DSP raises DSP-to-host interrupt
      dsp_wr(2, 16'h8055);
      expect_both(2, 16'hE055, "R2 d2h set");
      expect_val(K_PINS, 0, 32'h3, "R8 host_irq high");
      // R4 host clears it
      host_wr(2, 32'h0000_0000);
      expect_both(2, 16'h0055, "R4 d2h clear");
      expect_val(K_PINS, 0, 32'h2, "R8 host_irq low");

      // R7 raise and lowering on the same edge
      both_wr(1, 32'h0000_8007, 1, 16'h0000);
      expect_both(1, 16'hE007, "R7 set wins");
      expect_val(K_PINS, 0, 32'h0, "R7 irq kept");
      dsp_wr(1, 16'h0000);
      expect_val(K_HOST, 1, 32'h0000_0007, "R7 later clear");

      // R9 token byte ownership
      host_wr(0, 32'hFFFF_FFFF);
      expect_both(0, 16'h00FF, "R9 host low byte");
      dsp_wr(0, 16'hA5FF);
      expect_val(K_HOST, 0, 32'h0000_A5FF, "R9 dsp high byte");
      both_wr(0, 32'h0000_3C00, 0, 16'h1234);
      expect_both(0, 16'h1200, "R9 same-cycle lanes");

      // R10 setup phase alone does not write
      host_setup_only(0, 32'h0000_00EE);
      expect_val(K_DSP, 0, 32'h0000_1200, "R10 setup only");
      // R10 unused index reads zero
      expect_both(3, 16'h0000, "R10 idx3");
      // R10 read data gated by select
      @(negedge clk);
      #1;
      total++;
      if (prdata !== 32'h0 || dsp_rdata !== 16'h0) begin
         bad++;
         $display("FAIL R10 unselected act=%h/%h exp=0/0", prdata, dsp_rdata);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule